// File: doc/BRIEF.md
# Transient fault error record unit

This block gathers the parity mismatch flags raised by many small groups of protected flip-flops inside a processor core and turns them into a single architectural error record. Flags are grouped by functional unit: every unit owns a fixed number of parity groups, and any one of them reporting a mismatch marks that unit as faulty. When error detection is switched on, the first faulty unit seen is written into a status register as an uncorrected, uncontainable error with a fixed syndrome. The record carries a 5-bit implementation code that names the unit. A fault handling interrupt is raised for as long as the record is valid.

Software uses a two-word register port. One word is a control register holding a global detection enable and a separate transient-fault enable. The other word is the status register. Software reads the record and retires it by writing a one to its valid bit. Further faults that arrive while a record is held do not replace it; they set a sticky overflow flag instead.

Top module: `tf_err_record`

## Requirements
- R1: A unit counts as faulty when any one of its parity groups raises its flag; flag bit `u*GRP_PER_UNIT + g` belongs to group g of unit u.
- R2: A fault is recorded only when control bit 0 (global detection enable) and control bit 33 (transient-fault enable) are both 1; with either bit at 0, flags leave the status register unchanged.
- R3: A recorded fault reads back at word 1 with valid at bit 31 = 1, uncorrected at bit 29 = 1, error type in bits 23:22 = 2'b00 and syndrome in bits 7:0 = 8'h1A.
- R4: The unit code in status bits 12:8 is 4 + u for unit index u: data side 4, vector 5, MMU 6, L2 cache 7, interrupt CPU interface 8, debug trace 9, instruction side 10, decode 11, rename 12, commit 13, issue 14, integer execute 15, bus bridge 16.
- R5: When several units are faulty in the same cycle, the lowest unit code is recorded.
- R6: A fault arriving while a record is valid, and not in a cycle that clears it, leaves the code unchanged and sets the sticky overflow flag at status bit 27.
- R7: The interrupt output rises on the clock edge that records a fault and stays high while the record is valid.
- R8: Writing status word 1 with bit 31 set clears the record, the overflow flag and the interrupt from the next cycle; a write with bit 31 at 0 changes nothing.
- R9: While no record is valid, the whole status word, including the unit code, reads as zero.
- R10: A fault in the same cycle as a clearing write is recorded as a fresh record with the overflow flag at 0.
- R11: Control word 0 reads back bit 0 and bit 33 as last written, all other bits 0; any address other than 0 and 1 reads zero and ignores writes; after reset both words read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_flags | input | 13*GRP_PER_UNIT | Parity mismatch flag per protection group |
| reg_addr | input | ADDR_W | Register word address (0 control, 1 status) |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the addressed word, combinational |
| fault_irq | output | 1 | Fault handling interrupt |

## Verification
The hardest situation to reach is a fault that lands in exactly the cycle software retires the previous record, because the clear and the new capture compete for the same register. The stimulus first builds a valid record, then drives the clearing write and a new unit flag in one cycle, and also drives a clear with no flag and a fault with overflow pending. A behavioural model compares the interrupt and the addressed register word on every clock, so each of these orderings is checked the cycle it happens.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

    localparam int N_UNITS    = 13;
    localparam int REG_W      = 64;
    localparam int CODE_W     = 5;
    localparam int CODE_BASE  = 4;
    localparam logic [7:0] SYNDROME_TF = 8'h1A;
    localparam logic [1:0] TYPE_UNCONTAINED = 2'b00;

    localparam int CTRL_DET_BIT  = 0;
    localparam int CTRL_TF_BIT   = 33;
    localparam int STAT_V_BIT    = 31;
    localparam int STAT_UE_BIT   = 29;
    localparam int STAT_OVF_BIT  = 27;
    localparam int STAT_TYPE_LSB = 22;
    localparam int STAT_CODE_LSB = 8;

    localparam int WORD_CTRL = 0;
    localparam int WORD_STAT = 1;

    typedef logic [CODE_W-1:0] unit_code_t;

    typedef enum logic [CODE_W-1:0] {
        UC_DATA_SIDE  = 5'd4,
        UC_VECTOR     = 5'd5,
        UC_MMU        = 5'd6,
        UC_L2         = 5'd7,
        UC_IRQ_IF     = 5'd8,
        UC_TRACE      = 5'd9,
        UC_INSTR_SIDE = 5'd10,
        UC_DECODE     = 5'd11,
        UC_RENAME     = 5'd12,
        UC_COMMIT     = 5'd13,
        UC_ISSUE      = 5'd14,
        UC_INT_EXEC   = 5'd15,
        UC_BUS_BRIDGE = 5'd16
    } unit_id_e;

    typedef struct packed {
        logic       v;
        logic       ue;
        logic [1:0] etype;
        logic       ovf;
        unit_code_t code;
        logic [7:0] syn;
    } err_rec_t;

    typedef struct packed {
        logic det_en;
        logic tf_en;
    } ctrl_t;

    function automatic unit_code_t code_of(input int idx);
        return unit_code_t'(CODE_BASE + idx);
    endfunction

    function automatic err_rec_t fresh_record(input unit_code_t c);
        err_rec_t r;
        r.v     = 1'b1;
        r.ue    = 1'b1;
        r.etype = TYPE_UNCONTAINED;
        r.ovf   = 1'b0;
        r.code  = c;
        r.syn   = SYNDROME_TF;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CTRL_DET_BIT] = c.det_en;
        w[CTRL_TF_BIT]  = c.tf_en;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input err_rec_t r);
        logic [REG_W-1:0] w;
        w = '0;
        if (r.v) begin
            w[STAT_V_BIT]   = 1'b1;
            w[STAT_UE_BIT]  = r.ue;
            w[STAT_OVF_BIT] = r.ovf;
            w[STAT_TYPE_LSB +: 2]      = r.etype;
            w[STAT_CODE_LSB +: CODE_W] = r.code;
            w[7:0]          = r.syn;
        end
        return w;
    endfunction

endpackage

// File: rtl/tfr_unit_reduce.sv
module tfr_unit_reduce #(
    parameter int N_UNITS      = 13,
    parameter int GRP_PER_UNIT = 4
) (
    input  logic [N_UNITS*GRP_PER_UNIT-1:0] grp_flags,
    output logic [N_UNITS-1:0]              unit_err
);
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        assign unit_err[u] = |grp_flags[u*GRP_PER_UNIT +: GRP_PER_UNIT];
    end
endmodule

// File: rtl/tfr_prio_pick.sv
module tfr_prio_pick
    import tfr_pkg::*;
#(
    parameter int N_UNITS = 13
) (
    input  logic [N_UNITS-1:0] unit_err,
    output logic               any_err,
    output unit_code_t         win_code
);
    always_comb begin
        win_code = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (unit_err[i]) begin
                win_code = code_of(i);
            end
        end
    end

    assign any_err = |unit_err;
endmodule

// File: rtl/tfr_ctrl_reg.sv
module tfr_ctrl_reg
    import tfr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  det_bit,
    input  logic  tf_bit,
    output ctrl_t ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.det_en <= det_bit;
            ctrl.tf_en  <= tf_bit;
        end
    end
endmodule

// File: rtl/tfr_status_rec.sv
module tfr_status_rec
    import tfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       err_in,
    input  unit_code_t err_code,
    input  logic       clr,
    output err_rec_t   rec,
    output logic       irq
);
    err_rec_t rec_d;
    logic     held;

    assign held = rec.v && !clr;

    always_comb begin
        rec_d = rec;
        if (err_in) begin
            if (held) begin
                rec_d.ovf = 1'b1;
            end else begin
                rec_d = fresh_record(err_code);
            end
        end else if (clr) begin
            rec_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec <= '0;
            irq <= 1'b0;
        end else begin
            rec <= rec_d;
            irq <= rec_d.v;
        end
    end
endmodule

// File: rtl/tf_err_record.sv
module tf_err_record
    import tfr_pkg::*;
#(
    parameter int GRP_PER_UNIT = 4,
    parameter int ADDR_W       = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_UNITS*GRP_PER_UNIT-1:0] grp_flags,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic                            reg_wr,
    input  logic [REG_W-1:0]                reg_wdata,
    output logic [REG_W-1:0]                reg_rdata,
    output logic                            fault_irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WORD_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WORD_STAT);

    logic [N_UNITS-1:0] unit_err;
    logic               any_err;
    unit_code_t         win_code;
    ctrl_t              ctrl;
    err_rec_t           rec;
    logic               det_en;
    logic               clr_req;
    logic               ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign clr_req = reg_wr && (reg_addr == A_STAT) && reg_wdata[STAT_V_BIT];
    assign det_en  = ctrl.det_en && ctrl.tf_en;

    tfr_unit_reduce #(
        .N_UNITS      (N_UNITS),
        .GRP_PER_UNIT (GRP_PER_UNIT)
    ) u_reduce (
        .grp_flags (grp_flags),
        .unit_err  (unit_err)
    );

    tfr_prio_pick #(
        .N_UNITS (N_UNITS)
    ) u_pick (
        .unit_err (unit_err),
        .any_err  (any_err),
        .win_code (win_code)
    );

    tfr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctrl_wr),
        .det_bit (reg_wdata[CTRL_DET_BIT]),
        .tf_bit  (reg_wdata[CTRL_TF_BIT]),
        .ctrl    (ctrl)
    );

    tfr_status_rec u_rec (
        .clk      (clk),
        .rst      (rst),
        .err_in   (any_err && det_en),
        .err_code (win_code),
        .clr      (clr_req),
        .rec      (rec),
        .irq      (fault_irq)
    );

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = pack_ctrl(ctrl);
            A_STAT:  reg_rdata = pack_status(rec);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tf_err_record_chk.sv
module tf_err_record_chk
    import tfr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               irq,
    input logic               det_en,
    input logic               clr_req,
    input logic [N_UNITS-1:0] unit_err,
    input err_rec_t           rec
);
    logic hit;
    assign hit = det_en && (|unit_err);

    p_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        (!det_en && !rec.v) |=> !rec.v);

    p_fixed_fields_r3: assert property (@(posedge clk) disable iff (rst)
        rec.v |-> (rec.ue && rec.etype == 2'b00 && rec.syn == 8'h1A));

    p_code_range_r4: assert property (@(posedge clk) disable iff (rst)
        rec.v |-> (rec.code >= 5'd4 && rec.code <= 5'd16));

    p_hold_code_r6: assert property (@(posedge clk) disable iff (rst)
        (rec.v && !clr_req) |=> (rec.v && rec.code == $past(rec.code)));

    p_overflow_set_r6: assert property (@(posedge clk) disable iff (rst)
        (rec.v && !clr_req && hit) |=> rec.ovf);

    p_overflow_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rec.ovf |-> rec.v);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(hit));

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> (!rec.v && !irq));

    p_fresh_r10: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_req) |=> (rec.v && !rec.ovf && irq));
endmodule

bind tf_err_record tf_err_record_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (fault_irq),
    .det_en   (det_en),
    .clr_req  (clr_req),
    .unit_err (unit_err),
    .rec      (rec)
);

// File: tb/tf_err_record_tb.sv
`timescale 1ns/1ps
module tf_err_record_tb;
    localparam int NU = 13;
    localparam int G  = 4;
    localparam int NF = NU * G;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NF-1:0] flags = '0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [63:0]   wdata = '0;
    logic [63:0]   rdata;
    logic          irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_req = "R11";

    bit       m_v, m_ovf, m_det, m_tf;
    int       m_code;

    always #5 clk = ~clk;

    tf_err_record #(.GRP_PER_UNIT(G), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .grp_flags(flags), .reg_addr(addr),
        .reg_wr(wr_en), .reg_wdata(wdata), .reg_rdata(rdata), .fault_irq(irq)
    );

    // behavioural reference model
    always @(posedge clk) begin
        automatic bit clr = wr_en && addr == 1 && wdata[31];
        automatic int low = -1;
        for (int k = 0; k < NF; k++)
            if (flags[k] && (low < 0 || k / G < low)) low = k / G;
        if (rst) begin
            m_v <= 0; m_ovf <= 0; m_code <= 0; m_det <= 0; m_tf <= 0;
        end else begin
            if (low >= 0 && m_det && m_tf) begin
                if (m_v && !clr) m_ovf <= 1;
                else begin m_v <= 1; m_ovf <= 0; m_code <= 4 + low; end
            end else if (clr) begin
                m_v <= 0; m_ovf <= 0; m_code <= 0;
            end
            if (wr_en && addr == 0) begin
                m_det <= wdata[0];
                m_tf  <= wdata[33];
            end
        end
    end

    function automatic logic [63:0] exp_read();
        logic [63:0] e = '0;
        if (addr == 0) begin
            e[0] = m_det; e[33] = m_tf;
        end else if (addr == 1 && m_v) begin
            e[31] = 1; e[29] = 1; e[27] = m_ovf;
            e[12:8] = 5'(m_code); e[7:0] = 8'h1A;
        end
        return e;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            compared++;
            if (rdata !== exp_read() || irq !== m_v) begin
                mismatched++;
                $display("FAIL %s t=%0t addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         cur_req, $time, addr, rdata, irq, exp_read(), m_v);
            end
        end
    end

    task automatic cyc(input logic [NF-1:0] f, input logic w,
                       input logic [AW-1:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        flags = f; wr_en = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n, input logic [AW-1:0] a);
        for (int i = 0; i < n; i++) cyc('0, 0, a, '0);
    endtask

    function automatic logic [NF-1:0] uf(input int u, input int g);
        logic [NF-1:0] f = '0;
        f[u*G + g] = 1'b1;
        return f;
    endfunction

    localparam logic [63:0] EN_BOTH = (64'd1 << 33) | 64'd1;
    localparam logic [63:0] CLR     = 64'd1 << 31;

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R11 reset state and unmapped addresses
        cur_req = "R11";
        idle(2, 0); idle(2, 1); idle(2, 5);
        cyc('0, 1, 5, '1); idle(2, 0); idle(1, 5);
        // R2 only one enable set
        cur_req = "R2";
        cyc('0, 1, 0, 64'd1); cyc(uf(3, 1), 0, 1, '0); idle(3, 1);
        cyc('0, 1, 0, 64'd1 << 33); cyc(uf(8, 2), 0, 1, '0); idle(3, 1);
        cyc('0, 1, 0, EN_BOTH); idle(2, 0);
        // R1 R4 R3 R7 each unit through a different group
        cur_req = "R4";
        for (int u = 0; u < NU; u++) begin
            cyc(uf(u, u % G), 0, 1, '0);
            idle(2, 1);
            cyc('0, 1, 1, CLR);
            idle(1, 1);
        end
        cur_req = "R1";
        cyc(uf(12, 3) | uf(12, 0), 0, 1, '0); idle(2, 1); cyc('0, 1, 1, CLR); idle(1, 1);
        // R5 simultaneous units
        cur_req = "R5";
        cyc(uf(9, 0) | uf(2, 3) | uf(11, 1), 0, 1, '0); idle(2, 1);
        // R6 overflow while valid
        cur_req = "R6";
        cyc(uf(0, 0), 0, 1, '0); idle(2, 1); cyc(uf(5, 2), 0, 1, '0); idle(2, 1);
        // R8 write without bit 31 does nothing, then clear
        cur_req = "R8";
        cyc('0, 1, 1, ~CLR); idle(2, 1);
        cyc('0, 1, 1, CLR); idle(2, 1);
        // R9 zero status when empty
        cur_req = "R9";
        idle(3, 1);
        // R10 clear racing a new fault
        cur_req = "R10";
        cyc(uf(6, 1), 0, 1, '0); cyc(uf(4, 0), 0, 1, '0); idle(1, 1);
        cyc(uf(7, 2), 1, 1, CLR); idle(3, 1);
        // R2 disabling holds the record, then no new capture
        cur_req = "R2";
        cyc('0, 1, 0, 64'd1 << 33); idle(1, 1);
        cyc('0, 1, 1, CLR); cyc(uf(1, 0), 0, 1, '0); idle(3, 1);
        // R7 interrupt and record after reenable
        cur_req = "R7";
        cyc('0, 1, 0, EN_BOTH); cyc(uf(10, 3), 0, 1, '0); idle(3, 1);
        cur_req = "R11";
        idle(2, 0);
        finish_run();
    end
endmodule